// File: doc/BRIEF.md
# Windowed Oscillation Count Sequencer

This block measures how fast a free-running on-chip oscillator runs by counting its cycles inside a time window supplied from outside. It enables the oscillator, waits for the window to open, clears and runs a counter on every oscillator rising edge, freezes and captures the count when the window closes, shuts the oscillator off, and then gives a downstream threshold comparator one clock cycle in which to compare the captured value. It then returns to its starting phase, so measurements repeat back to back.

Both the oscillator pulse and the window signal arrive asynchronously. Each passes through a two-flop synchronizer before any edge is detected. The sequence runs through four phases with fixed 2-bit codes. The current code is brought out on a port so that the phase can be observed.

Top module: `osc_window_seq`

## Requirements
- R1: While `rst_n` is low, and at once without a clock edge, the outputs are `phase`=00, `osc_en`=1, `load_stb`=0, `clr_stb`=0, `cmp_en`=0 and `count_q`=0. Reset is released internally after two clock edges.
- R2: `phase` uses these codes: 00 start (oscillator enabled, waiting), 01 counting, 11 load, 10 compare. `osc_en` is 1 in phases 00 and 01 and 0 in phases 11 and 10.
- R3: In phase 00, a rising edge of `win_in` moves the block to phase 01. The edge is seen two clock edges after `win_in` is first sampled high. On that move the counter is zeroed, and `clr_stb` is high for exactly the first cycle of phase 01.
- R4: In phase 01, each rising edge of `osc_in` adds one to the counter. The edge is detected after two synchronizer flops.
- R5: The counter saturates at 127 and does not wrap.
- R6: In phase 01, a falling edge of the synchronized window moves the block to phase 11. Phase 11 lasts exactly one cycle, with `load_stb` high. At the end of that cycle the count is captured, and from the next cycle `count_q` shows it. `count_q` changes at no other time except reset.
- R7: Phase 10 follows phase 11. It lasts one cycle with `cmp_en` high, and the block then returns to phase 00. `cmp_en` is high in no other phase.
- R8: A window rising edge seen outside phase 00 is ignored, and the block then needs a fresh rising edge after reaching phase 00. Oscillator edges seen outside phase 01 do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 1 | Oscillator pulse, asynchronous |
| win_in | input | 1 | Measurement window, asynchronous, high while open |
| osc_en | output | 1 | Oscillator enable |
| phase | output | 2 | Current phase code |
| count_q | output | 7 | Captured oscillation count |
| load_stb | output | 1 | One-cycle capture strobe |
| clr_stb | output | 1 | One-cycle counter-restart strobe |
| cmp_en | output | 1 | One-cycle compare enable |

## Verification
The oscillator is driven at several speeds: toggling every cycle, toggling every two or three cycles, and stopped. This separates correct edge counting from an off-by-one in the synchronizer, and a zero result from a counter that was never cleared. A long window at the fastest speed pushes the count past 127 to show saturation against wrap-around, and a one-cycle window checks the shortest path through all four phases. A free-running oscillator left on through the waiting phase, and a window that drops and returns within one cycle, show that edges seen in the wrong phase are ignored. A reset applied in the middle of a count shows the asynchronous return to the start values.

// File: rtl/ows_pkg.sv
package ows_pkg;
  typedef enum logic [1:0] {
    PH_START = 2'b00,
    PH_COUNT = 2'b01,
    PH_LOAD  = 2'b11,
    PH_CMP   = 2'b10
  } phase_e;
endpackage

// File: rtl/ows_rst_sync.sv
// Asynchronous assert, synchronous release of the internal reset.
module ows_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_i_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_i_n = chain_q[STAGES-1];
endmodule

// File: rtl/ows_sync.sv
// Multi-bit level synchronizer, one independent chain per bit.
module ows_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= '0;
          else        stage_q[gi] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[gi] <= '0;
          else        stage_q[gi] <= stage_q[gi-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ows_win_edge.sv
// Rising and falling edge detection on the synchronized window level.
module ows_win_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/ows_fsm.sv
// Phase sequencer: start -> count -> load -> compare -> start.
module ows_fsm
  import ows_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       win_rise,
  input  logic       win_fall,
  output phase_e     phase,
  output logic       clr_cmd,
  output logic       cnt_en,
  output logic       cap_en,
  output logic       osc_en,
  output logic       clr_stb,
  output logic       load_stb,
  output logic       cmp_en
);
  phase_e state_q, state_d;
  logic   clr_stb_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_START: if (win_rise) state_d = PH_COUNT;
      PH_COUNT: if (win_fall) state_d = PH_LOAD;
      PH_LOAD:  state_d = PH_CMP;
      PH_CMP:   state_d = PH_START;
      default:  state_d = PH_START;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PH_START;
    else        state_q <= state_d;
  end

  assign clr_cmd = (state_q == PH_START) && win_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clr_stb_q <= 1'b0;
    else        clr_stb_q <= clr_cmd;
  end

  assign phase    = state_q;
  assign cnt_en   = (state_q == PH_COUNT);
  assign cap_en   = (state_q == PH_LOAD);
  assign osc_en   = (state_q == PH_START) || (state_q == PH_COUNT);
  assign clr_stb  = clr_stb_q;
  assign load_stb = (state_q == PH_LOAD);
  assign cmp_en   = (state_q == PH_CMP);
endmodule

// File: rtl/ows_counter.sv
// Saturating oscillation counter with capture register.
module ows_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_lvl,
  input  logic             clr_cmd,
  input  logic             cnt_en,
  input  logic             cap_en,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             osc_prev_q;
  logic             osc_rise;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_we;
  logic [CNT_W-1:0] cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) osc_prev_q <= 1'b0;
    else        osc_prev_q <= osc_lvl;
  end

  assign osc_rise = osc_lvl & ~osc_prev_q;

  always_comb begin
    cnt_we = 1'b0;
    cnt_d  = cnt_q;
    if (clr_cmd) begin
      cnt_we = 1'b1;
      cnt_d  = '0;
    end else if (cnt_en && osc_rise && (cnt_q != CNT_MAX)) begin
      cnt_we = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= '0;
    else if (cap_en) cap_q <= cnt_q;
  end

  assign cnt = cnt_q;
  assign cap = cap_q;
endmodule

// File: rtl/osc_window_seq.sv
module osc_window_seq
  import ows_pkg::*;
#(
  parameter int CNT_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_in,
  input  logic             win_in,
  output logic             osc_en,
  output logic [1:0]       phase,
  output logic [CNT_W-1:0] count_q,
  output logic             load_stb,
  output logic             clr_stb,
  output logic             cmp_en
);
  logic             rst_i_n;
  logic [1:0]       raw_in, sync_in;
  logic             win_rise, win_fall;
  logic             clr_cmd, cnt_en, cap_en;
  phase_e           ph;
  logic [CNT_W-1:0] cnt_val;

  ows_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_i_n(rst_i_n)
  );

  assign raw_in = {win_in, osc_in};

  ows_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_i_n), .d(raw_in), .q(sync_in)
  );

  ows_win_edge u_wedge (
    .clk(clk), .rst_n(rst_i_n), .lvl(sync_in[1]),
    .rise(win_rise), .fall(win_fall)
  );

  ows_fsm u_fsm (
    .clk(clk), .rst_n(rst_i_n),
    .win_rise(win_rise), .win_fall(win_fall),
    .phase(ph), .clr_cmd(clr_cmd), .cnt_en(cnt_en), .cap_en(cap_en),
    .osc_en(osc_en), .clr_stb(clr_stb), .load_stb(load_stb), .cmp_en(cmp_en)
  );

  ows_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .osc_lvl(sync_in[0]),
    .clr_cmd(clr_cmd), .cnt_en(cnt_en), .cap_en(cap_en),
    .cnt(cnt_val), .cap(count_q)
  );

  assign phase = ph;
endmodule

// File: rtl/ows_chk.sv
module ows_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       phase,
  input logic             osc_en,
  input logic             load_stb,
  input logic             clr_stb,
  input logic             cmp_en,
  input logic [CNT_W-1:0] count_q,
  input logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r2_start_next: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'b00 |=> (phase == 2'b00 || phase == 2'b01));
  a_r2_count_next: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'b01 |=> (phase == 2'b01 || phase == 2'b11));
  a_r6_load_next: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'b11 |=> phase == 2'b10);
  a_r7_cmp_next: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'b10 |=> phase == 2'b00);
  a_r6_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> !load_stb);
  a_r3_clr_entry: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |-> (phase == 2'b01 && $past(phase) == 2'b00 && cnt == '0));
  a_r7_cmp_alone: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_en |-> (!load_stb && !osc_en));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load_stb) |-> $stable(count_q));
  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && phase != 2'b00) |=> cnt == CNT_MAX);
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'b11 || phase == 2'b10) |=> $stable(cnt));
endmodule

bind osc_window_seq ows_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .phase(phase), .osc_en(osc_en),
  .load_stb(load_stb), .clr_stb(clr_stb), .cmp_en(cmp_en),
  .count_q(count_q), .cnt(cnt_val)
);

// File: tb/tb_osc_window_seq.sv
`timescale 1ns/1ps
module tb_osc_window_seq;
  logic       clk = 1'b0;
  logic       rst_n, osc_in, win_in;
  logic       osc_en, load_stb, clr_stb, cmp_en;
  logic [1:0] phase;
  logic [6:0] count_q;

  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  osc_window_seq dut (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .win_in(win_in),
    .osc_en(osc_en), .phase(phase), .count_q(count_q),
    .load_stb(load_stb), .clr_stb(clr_stb), .cmp_en(cmp_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Reference model, updated on each rising edge from sampled inputs.
  bit model_on = 0;
  bit wq[$], oq[$];
  int m_ph, m_cnt, m_cap;
  bit m_clr;

  task automatic model_reset();
    wq = '{0, 0, 0};
    oq = '{0, 0, 0};
    m_ph = 0; m_cnt = 0; m_cap = 0; m_clr = 0;
  endtask

  always @(posedge clk) begin
    if (model_on) begin
      bit wr, wf, orr;
      wr  = wq[1] && !wq[2];
      wf  = !wq[1] && wq[2];
      orr = oq[1] && !oq[2];
      m_clr = 0;
      case (m_ph)
        0: if (wr) begin m_ph = 1; m_cnt = 0; m_clr = 1; end
        1: begin
             if (orr && m_cnt < 127) m_cnt++;
             if (wf) m_ph = 3;
           end
        3: begin m_cap = m_cnt; m_ph = 2; end
        default: m_ph = 0;
      endcase
      wq.push_front(win_in); void'(wq.pop_back());
      oq.push_front(osc_in); void'(oq.pop_back());
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      chk(phase == m_ph[1:0], "R2 phase", phase, m_ph);
      chk(osc_en == (m_ph == 0 || m_ph == 1), "R2 osc_en", osc_en, (m_ph == 0 || m_ph == 1));
      chk(clr_stb == m_clr, "R3 clr_stb", clr_stb, m_clr);
      chk(load_stb == (m_ph == 3), "R6 load_stb", load_stb, (m_ph == 3));
      chk(cmp_en == (m_ph == 2), "R7 cmp_en", cmp_en, (m_ph == 2));
      chk(count_q == m_cap[6:0], "R6 count_q", count_q, m_cap);
    end
  end

  // Oscillator stimulus: toggles every osc_half cycles, gated by osc_en unless free.
  int osc_half = 0;
  bit osc_free = 0;
  int osc_ph = 0;
  always @(negedge clk) begin
    if (osc_half == 0) begin
      osc_in = 1'b0; osc_ph = 0;
    end else if (!osc_free && !osc_en) begin
      osc_in = 1'b0; osc_ph = 0;
    end else begin
      osc_ph++;
      if (osc_ph >= osc_half) begin osc_ph = 0; osc_in = ~osc_in; end
    end
  end

  task automatic check_reset_values(input string tag);
    chk(phase == 2'b00, {tag, " phase"}, phase, 0);
    chk(osc_en == 1'b1, {tag, " osc_en"}, osc_en, 1);
    chk(load_stb == 1'b0 && clr_stb == 1'b0 && cmp_en == 1'b0,
        {tag, " strobes"}, {load_stb, clr_stb, cmp_en}, 0);
    chk(count_q == 7'd0, {tag, " count_q"}, count_q, 0);
  endtask

  task automatic wait_cmp();
    for (int i = 0; i < 20 && phase != 2'b10; i++) @(negedge clk);
  endtask

  task automatic window(input int pre, input int len);
    win_in = 1'b0;
    repeat (pre) @(negedge clk);
    win_in = 1'b1;
    repeat (len) @(negedge clk);
    win_in = 1'b0;
    wait_cmp();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b1; osc_in = 1'b0; win_in = 1'b0;
    #0.5 rst_n = 1'b0;
    #0.5 check_reset_values("R1 time-zero");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    model_reset();
    model_on = 1;

    // R4: moderate oscillator
    osc_half = 2;
    window(6, 40);
    chk(phase == 2'b10 && count_q == m_cap[6:0] && count_q > 0, "R4 count half=2", count_q, m_cap);
    // R4: fastest oscillator
    osc_half = 1;
    window(5, 30);
    chk(phase == 2'b10 && count_q == m_cap[6:0], "R4 count half=1", count_q, m_cap);
    // R4: stopped oscillator gives zero
    osc_half = 0;
    window(5, 20);
    chk(count_q == 7'd0, "R4 count stopped", count_q, 0);
    // R5: saturation
    osc_half = 1;
    window(5, 400);
    chk(count_q == 7'd127, "R5 saturate", count_q, 127);
    // R8: free-running oscillator during start phase is ignored
    osc_free = 1; osc_half = 3;
    window(30, 25);
    chk(count_q == m_cap[6:0] && count_q <= 7'd5, "R8 start edges ignored", count_q, m_cap);
    osc_free = 0;
    // R3/R6/R7: one-cycle window
    osc_half = 1;
    window(5, 1);
    chk(phase == 2'b10 && cmp_en, "R7 short window compare", phase, 2);
    // R8: window re-rise during load/compare is ignored
    win_in = 1'b0; repeat (5) @(negedge clk);
    win_in = 1'b1; repeat (20) @(negedge clk);
    win_in = 1'b0; @(negedge clk);
    win_in = 1'b1; repeat (25) @(negedge clk);
    chk(phase == 2'b00, "R8 re-rise ignored", phase, 0);
    window(4, 15);
    chk(phase == 2'b10 && count_q == m_cap[6:0], "R3 fresh window counts", count_q, m_cap);
    // R1: reset mid-count
    win_in = 1'b0; repeat (4) @(negedge clk);
    win_in = 1'b1; repeat (10) @(negedge clk);
    chk(phase == 2'b01, "R3 counting before reset", phase, 1);
    model_on = 0;
    #1 rst_n = 1'b0;
    #0.5 check_reset_values("R1 mid-run");
    win_in = 1'b0; osc_half = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    model_reset();
    model_on = 1;
    osc_half = 2;
    window(3, 20);
    chk(count_q == m_cap[6:0], "R6 after reset capture", count_q, m_cap);
    repeat (5) @(negedge clk);
    model_on = 0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule